// File: doc/BRIEF.md
# Packed SIMD Logical Left Shifter

This unit performs a lane-parallel logical left shift on a 256-bit vector. The source vector is viewed as packed 16-, 32- or 64-bit elements, and every element is shifted left by the same count. Vacated low bits are filled with zeros, and bits pushed past the top of an element are dropped. Bits never spill into the neighbouring element. The count comes either from an 8-bit immediate, zero-extended, or from the low 64 bits of a 128-bit count operand. Any count at or above the element width gives zero elements; it does not wrap.

A two-bit mode input sets the width of the operation. In the preserving 128-bit form, only the low 128 bits are shifted and the high half of the result carries the previous destination value, which is supplied on its own input. In the clearing 128-bit form, the high half is forced to zero. In the 256-bit form, both halves are shifted with the same count. One registered stage sits between the operands and the result: an operation is accepted when `inValid` is high, and its result appears with `outValid` on the next clock.

Top module: `simd_lshift_unit`

## Requirements
- R1: `elemSel` picks the element width: 00 for 16-bit, 01 for 32-bit, 10 for 64-bit. Each element of the shifted region is shifted left by the count, with zeros entering at bit 0. Bits leaving the top of an element are discarded and never enter the next element.
- R2: A count greater than 15 (16-bit), 31 (32-bit) or 63 (64-bit) makes every element of the shifted region zero.
- R3: When the vector count is used, only `countVec[63:0]` forms the count and `countVec[127:64]` has no effect. A low part such as 2^32 is out of range and zeroes the shifted region.
- R4: With `useImm`=1 the count is `countImm`, zero-extended, and `countVec` is ignored. With `useImm`=0 the count is taken from `countVec` and `countImm` is ignored.
- R5: With `modeSel`=00, bits 127:0 are shifted and `result[255:128]` equals `prevDst[255:128]` captured with the operation.
- R6: With `modeSel`=01, bits 127:0 are shifted and `result[255:128]` is zero.
- R7: With `modeSel`=10 or 11, all 256 bits are shifted elementwise with one count.
- R8: `elemSel`=11 is reserved and produces an all-zero 256-bit result in every mode.
- R9: The operands are captured on a clock edge where `inValid`=1. `result` and `outValid`=1 appear after that edge. On an edge with `inValid`=0, `outValid` goes to 0 and `result` holds its value.
- R10: A synchronous active-high `rst` clears `outValid` and `result`, and it takes priority over `inValid`.
- R11: A count of zero returns each element unchanged in the shifted region. The high half still follows the mode rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operation accepted on this edge |
| srcVec | input | 256 | Source vector |
| prevDst | input | 256 | Previous destination contents, upper half used in mode 00 |
| countVec | input | 128 | Vector count operand, low 64 bits used |
| countImm | input | 8 | Immediate count |
| useImm | input | 1 | 1 selects immediate count, 0 selects vector count |
| elemSel | input | 2 | Element width code |
| modeSel | input | 2 | Operation width and upper-half handling |
| outValid | output | 1 | Result valid |
| result | output | 256 | Shifted vector |

## Verification
Every result and `outValid` is due exactly one rising edge after the edge that captured the operands. Reset clearing takes effect at the first edge with `rst` high. The bench applies inputs on the falling edge. At each rising edge it updates a behavioural model with the same inputs, then compares both outputs at the next falling edge, so each comparison lands in the cycle where the registered stage has changed. Idle cycles are compared too, which confirms that the result holds and that `outValid` drops.

// File: rtl/simd_lshift_pkg.sv
`timescale 1ns/1ps
package simd_lshift_pkg;
  localparam int QW = 64;
  localparam int SH_W = $clog2(QW);

  typedef enum logic [1:0] {
    ES_WORD  = 2'b00,
    ES_DWORD = 2'b01,
    ES_QWORD = 2'b10,
    ES_RSVD  = 2'b11
  } elem_e;

  typedef enum logic [1:0] {
    MD_KEEP_HI  = 2'b00,
    MD_CLEAR_HI = 2'b01,
    MD_FULL     = 2'b10,
    MD_FULL_ALT = 2'b11
  } mode_e;

  typedef struct packed {
    logic [SH_W-1:0] shAmt;
    logic            sizeW;
    logic            sizeD;
    logic            sizeQ;
    logic            zeroAll;
    logic            wipeAll;
    logic            keepUpper;
    logic            zeroUpper;
  } ctrl_t;
endpackage

// File: rtl/lshift_ctrl.sv
`timescale 1ns/1ps
module lshift_ctrl
  import simd_lshift_pkg::*;
#(
  parameter int CNT_W = 128,
  parameter int IMM_W = 8
) (
  input  logic             useImm,
  input  logic [CNT_W-1:0] countVec,
  input  logic [IMM_W-1:0] countImm,
  input  logic [1:0]       elemSel,
  input  logic [1:0]       modeSel,
  output ctrl_t            strobes
);
  localparam int LO_W = CNT_W / 2;

  logic [LO_W-1:0] effCount;
  logic            unusedCountHi;

  assign effCount      = useImm ? LO_W'(countImm) : countVec[LO_W-1:0];
  assign unusedCountHi = ^countVec[CNT_W-1:LO_W];

  always_comb begin
    strobes = '0;
    strobes.shAmt = effCount[SH_W-1:0];
    unique case (elem_e'(elemSel))
      ES_WORD: begin
        strobes.sizeW   = 1'b1;
        strobes.zeroAll = (effCount >= LO_W'(16));
      end
      ES_DWORD: begin
        strobes.sizeD   = 1'b1;
        strobes.zeroAll = (effCount >= LO_W'(32));
      end
      ES_QWORD: begin
        strobes.sizeQ   = 1'b1;
        strobes.zeroAll = (effCount >= LO_W'(QW));
      end
      default: begin
        strobes.zeroAll = 1'b1;
        strobes.wipeAll = 1'b1;
      end
    endcase
    unique case (mode_e'(modeSel))
      MD_KEEP_HI:  strobes.keepUpper = 1'b1;
      MD_CLEAR_HI: strobes.zeroUpper = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/lshift_datapath.sv
`timescale 1ns/1ps
module lshift_datapath
  import simd_lshift_pkg::*;
#(
  parameter int VEC_W = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  ctrl_t            strobes,
  input  logic [VEC_W-1:0] srcVec,
  input  logic [VEC_W-1:0] prevDst,
  output logic             outValid,
  output logic [VEC_W-1:0] result
);
  localparam int NUM_Q = VEC_W / QW;
  localparam int HALF  = VEC_W / 2;
  localparam int DW    = QW / 2;
  localparam int WW    = QW / 4;

  logic [VEC_W-1:0] laneVec;
  logic [VEC_W-1:0] nextRes;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_lane
    logic [QW-1:0] chunk, qRes, dRes, wRes;
    assign chunk = srcVec[q*QW +: QW];
    assign qRes  = chunk << strobes.shAmt;
    for (genvar d = 0; d < 2; d++) begin : g_dw
      assign dRes[d*DW +: DW] = chunk[d*DW +: DW] << strobes.shAmt[$clog2(DW)-1:0];
    end
    for (genvar w = 0; w < 4; w++) begin : g_w
      assign wRes[w*WW +: WW] = chunk[w*WW +: WW] << strobes.shAmt[$clog2(WW)-1:0];
    end
    always_comb begin
      if (strobes.zeroAll)    laneVec[q*QW +: QW] = '0;
      else if (strobes.sizeQ) laneVec[q*QW +: QW] = qRes;
      else if (strobes.sizeD) laneVec[q*QW +: QW] = dRes;
      else                    laneVec[q*QW +: QW] = wRes;
    end
  end

  always_comb begin
    if (strobes.wipeAll) begin
      nextRes = '0;
    end else begin
      nextRes[HALF-1:0] = laneVec[HALF-1:0];
      if (strobes.keepUpper)      nextRes[VEC_W-1:HALF] = prevDst[VEC_W-1:HALF];
      else if (strobes.zeroUpper) nextRes[VEC_W-1:HALF] = '0;
      else                        nextRes[VEC_W-1:HALF] = laneVec[VEC_W-1:HALF];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      result   <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) result <= nextRes;
    end
  end

  assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!inValid && !rst) |=> (!outValid && $stable(result)));
  assert_reset_R10: assert property (@(posedge clk)
    rst |=> (!outValid && result == '0));
  assert_keep_upper_R5: assert property (@(posedge clk) disable iff (rst)
    (inValid && strobes.keepUpper && !strobes.wipeAll) |=>
      result[VEC_W-1:HALF] == $past(prevDst[VEC_W-1:HALF]));
  assert_clear_upper_R6: assert property (@(posedge clk) disable iff (rst)
    (inValid && strobes.zeroUpper) |=> result[VEC_W-1:HALF] == '0);
  assert_range_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (inValid && strobes.zeroAll) |=> result[HALF-1:0] == '0);
  assert_reserved_R8: assert property (@(posedge clk) disable iff (rst)
    (inValid && strobes.wipeAll) |=> result == '0);
  assert_zero_count_R11: assert property (@(posedge clk) disable iff (rst)
    (inValid && !strobes.zeroAll && strobes.shAmt == '0) |=>
      result[HALF-1:0] == $past(srcVec[HALF-1:0]));
endmodule

// File: rtl/simd_lshift_unit.sv
`timescale 1ns/1ps
module simd_lshift_unit
  import simd_lshift_pkg::*;
#(
  parameter int VEC_W = 256,
  parameter int CNT_W = 128,
  parameter int IMM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [VEC_W-1:0] srcVec,
  input  logic [VEC_W-1:0] prevDst,
  input  logic [CNT_W-1:0] countVec,
  input  logic [IMM_W-1:0] countImm,
  input  logic             useImm,
  input  logic [1:0]       elemSel,
  input  logic [1:0]       modeSel,
  output logic             outValid,
  output logic [VEC_W-1:0] result
);
  ctrl_t strobes;

  lshift_ctrl #(.CNT_W(CNT_W), .IMM_W(IMM_W)) u_ctrl (
    .useImm   (useImm),
    .countVec (countVec),
    .countImm (countImm),
    .elemSel  (elemSel),
    .modeSel  (modeSel),
    .strobes  (strobes)
  );

  lshift_datapath #(.VEC_W(VEC_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobes  (strobes),
    .srcVec   (srcVec),
    .prevDst  (prevDst),
    .outValid (outValid),
    .result   (result)
  );
endmodule

// File: tb/sim_simd_lshift_unit.sv
`timescale 1ns/1ps
module sim_simd_lshift_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [255:0] srcVec = '0;
  logic [255:0] prevDst = '0;
  logic [127:0] countVec = '0;
  logic [7:0]   countImm = '0;
  logic         useImm = 1'b0;
  logic [1:0]   elemSel = '0;
  logic [1:0]   modeSel = '0;
  logic         outValid;
  logic [255:0] result;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic         expValid = 1'b0;
  logic [255:0] expRes = '0;

  always #2.5 clk = ~clk;

  simd_lshift_unit u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .srcVec(srcVec), .prevDst(prevDst),
    .countVec(countVec), .countImm(countImm), .useImm(useImm),
    .elemSel(elemSel), .modeSel(modeSel), .outValid(outValid), .result(result)
  );

  function automatic logic [255:0] model(
    input logic [255:0] src, input logic [255:0] prev, input logic [127:0] cv,
    input logic [7:0] imm, input logic ui, input logic [1:0] es, input logic [1:0] md);
    logic [255:0] r;
    longint unsigned cnt;
    int width, span;
    r = '0;
    if (es == 2'b11) return r;
    cnt = ui ? longint'(imm) : cv[63:0];
    width = (es == 2'b00) ? 16 : (es == 2'b01) ? 32 : 64;
    span = (md[1]) ? 256 : 128;
    if (md == 2'b00) r[255:128] = prev[255:128];
    for (int e = 0; e < span / width; e++)
      for (int b = 0; b < width; b++)
        if (cnt < longint'(width) && longint'(b) >= cnt)
          r[e*width + b] = src[e*width + b - int'(cnt)];
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      expValid <= 1'b0;
      expRes   <= '0;
    end else begin
      expValid <= inValid;
      if (inValid)
        expRes <= model(srcVec, prevDst, countVec, countImm, useImm, elemSel, modeSel);
    end
  end

  task automatic compare(input string tag);
    checks++;
    if (outValid !== expValid || result !== expRes) begin
      failures++;
      $display("FAIL %s: outValid=%0b result=%h expected outValid=%0b result=%h",
               tag, outValid, result, expValid, expRes);
    end
  endtask

  task automatic cycle(input string tag);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic op(input string tag, input logic [255:0] s, input logic [127:0] cv,
                    input logic [7:0] imm, input logic ui, input logic [1:0] es,
                    input logic [1:0] md);
    inValid = 1'b1; srcVec = s; countVec = cv; countImm = imm; useImm = ui;
    elemSel = es; modeSel = md;
    prevDst = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    cycle(tag);
  endtask

  localparam logic [255:0] PAT = {64'hF00D_8001_C3A5_7FFF, 64'h8000_0001_FFFF_0001,
                                  64'h1234_5678_9ABC_DEF0, 64'hA5A5_5A5A_8421_1248};

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    inValid = 1'b1; srcVec = PAT;
    cycle("R10 reset clears outputs");
    cycle("R10 reset beats inValid");
    rst = 1'b0;
    inValid = 1'b0;
    cycle("R9 idle after reset");

    op("R1 word shift by 3", PAT, '0, 8'd3, 1'b1, 2'b00, 2'b10);
    op("R1 dword shift by 7", PAT, '0, 8'd7, 1'b1, 2'b01, 2'b10);
    op("R1 qword shift by 13", PAT, '0, 8'd13, 1'b1, 2'b10, 2'b10);
    op("R1 word max count 15", PAT, '0, 8'd15, 1'b1, 2'b00, 2'b10);
    op("R2 word count 16", PAT, '0, 8'd16, 1'b1, 2'b00, 2'b10);
    op("R1 dword max count 31", PAT, '0, 8'd31, 1'b1, 2'b01, 2'b10);
    op("R2 dword count 32", PAT, '0, 8'd32, 1'b1, 2'b01, 2'b10);
    op("R1 qword max count 63", PAT, '0, 8'd63, 1'b1, 2'b10, 2'b10);
    op("R2 qword count 64", PAT, '0, 8'd64, 1'b1, 2'b10, 2'b10);
    op("R2 imm count 255", PAT, '0, 8'd255, 1'b1, 2'b00, 2'b01);
    op("R3 high count bits ignored", PAT, {64'hFFFF_FFFF_FFFF_FFFF, 64'd5}, 8'd0, 1'b0, 2'b01, 2'b10);
    op("R3 count 2^32 out of range", PAT, {64'd0, 64'h1_0000_0000}, 8'd1, 1'b0, 2'b10, 2'b10);
    op("R4 immediate overrides vector", PAT, {64'd0, 64'd40}, 8'd2, 1'b1, 2'b00, 2'b10);
    op("R4 vector overrides immediate", PAT, {64'd0, 64'd9}, 8'd0, 1'b0, 2'b00, 2'b10);
    op("R5 keep upper half", PAT, '0, 8'd4, 1'b1, 2'b01, 2'b00);
    op("R5 keep upper with range zero", PAT, '0, 8'd70, 1'b1, 2'b10, 2'b00);
    op("R6 clear upper half", PAT, '0, 8'd4, 1'b1, 2'b00, 2'b01);
    op("R7 full width mode 11", PAT, '0, 8'd5, 1'b1, 2'b10, 2'b11);
    op("R8 reserved size mode 00", PAT, '0, 8'd1, 1'b1, 2'b11, 2'b00);
    op("R8 reserved size mode 10", PAT, '0, 8'd0, 1'b1, 2'b11, 2'b10);
    op("R11 zero count word", PAT, '0, 8'd0, 1'b1, 2'b00, 2'b10);
    op("R11 zero count keep upper", PAT, '0, 8'd0, 1'b1, 2'b10, 2'b00);
    inValid = 1'b0; srcVec = ~PAT; countImm = 8'd1;
    cycle("R9 result holds when idle");
    cycle("R9 result holds second idle");

    for (int i = 0; i < 200; i++) begin
      logic [7:0] c;
      c = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 70);
      if ($urandom % 4 == 0) begin
        inValid = 1'b0;
        cycle("R9 random idle");
      end else begin
        op("R1 random op",
           {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom},
           {$urandom, $urandom, 32'd0, 32'(c)}, c, 1'($urandom), 2'($urandom), 2'($urandom));
      end
    end

    inValid = 1'b1; rst = 1'b1;
    cycle("R10 reset mid-run");
    rst = 1'b0; inValid = 1'b0;
    cycle("R10 idle after reset");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule